// File: doc/BRIEF.md
# Three-Wire Control Bus Slave

This block is the slave end of a three-wire control bus. The master drives a mode line and a bus clock, and both sides share one data line. The slave oversamples all three lines with its own system clock. It sees three phases. With the mode line LOW and clock pulses present, the phase is an address phase. With the mode line LOW and no clock pulses, the phase is a halt. With the mode line HIGH, the phase is a data phase. An accepted address selects one of four transfer types. After that, bytes are shifted in for the write types and shifted out for the read type.

The local side never sees the serial protocol. For each received byte it gets a one-cycle strobe that carries the byte and its index within the transfer. For the read type, the block raises a request with a byte index, and the local logic answers with that byte in the same cycle. The block does not interpret the contents of any byte. It provides a data output and an output enable for an external tri-state pad.

Top module: `tw_ctrl_slave`

## Requirements
- R1: After reset no transfer is selected (`sel_o` = 0), `bus_dat_oe_o` is 0, and neither `wr_stb_o` nor `rd_req_o` is asserted.
- R2: An address phase shifts in 8 bits on the rising edges of the bus clock while the mode line is LOW, least significant bit first. The address is decoded when the mode line returns HIGH. The byte 0x44, whose bits arrive in the order of 0x22, is therefore not accepted.
- R3: An address whose upper six bits are 001000 selects a transfer. Its two low bits give `xfer_type_o`: 00 one-byte extended write, 01 allocation write of open length, 10 two-byte settings write, 11 status/peak read. Each accepted address restarts the byte index at 0.
- R4: The following addresses deselect the slave: 0x00, any address whose upper bits differ from 001000, and any address phase with a clock-pulse count other than 0 or 8. While deselected, the following data phase produces no write strobe and `bus_dat_oe_o` stays 0.
- R5: For a write type, every 8 data bits, taken least significant bit first, produce one `wr_stb_o` pulse with `wr_byte_o` and `wr_idx_o`. An extended write accepts only byte 0. A settings write accepts only bytes 0 and 1. An allocation write accepts any number of bytes.
- R6: For the read type, a byte is requested at the start of the data phase and after each completed byte. The byte is sent least significant bit first, and the output advances after each rising edge of the bus clock. `bus_dat_oe_o` is 1 only during the data phase of a read selection.
- R7: The read byte index runs 0–1 for status and 2–5 for peak bytes, and it keeps counting until a new address arrives. Bytes beyond index 5 are sent as 0x00 without a request.
- R8: A halt keeps the selection and the byte index, and it discards a byte that is only partly shifted. A halt is the mode line going LOW and then HIGH with no clock edges in between.
- R9: A bus clock rising edge and a mode line change may be seen in the same system cycle. When they are, the bit is taken in the phase that was in effect before the mode change. This completes an 8th address bit or an 8th data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode_i | input | 1 | Mode line from the master |
| bus_clk_i | input | 1 | Bus clock from the master |
| bus_dat_i | input | 1 | Data line as seen at the pad |
| bus_dat_o | output | 1 | Serial read data toward the pad |
| bus_dat_oe_o | output | 1 | Output enable for the data pad |
| sel_o | output | 1 | A transfer is currently selected |
| xfer_type_o | output | 2 | Selected transfer type (low address bits) |
| wr_stb_o | output | 1 | One-cycle strobe for a received byte |
| wr_byte_o | output | 8 | Received byte |
| wr_idx_o | output | IDX_W | Index of the received byte within the transfer |
| rd_req_o | output | 1 | Request for a read byte |
| rd_idx_o | output | IDX_W | Index of the requested byte |
| rd_byte_i | input | 8 | Read byte, valid in the cycle `rd_req_o` is 1 |

## Verification
The bus clock and the mode line pass through matched synchronisers, so the last clock edge of a phase and the mode change that ends it can land in the same system cycle. The bench provokes this by changing both lines on the same driving edge. It does so once at the end of an address, where the mode line rises, and once at the end of a data byte, where the mode line falls. The coincidence is judged correct when the address is still accepted with the right type, and when the final byte still produces its strobe with the right value before the halt takes effect.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    XT_EXT   = 2'b00,
    XT_ALLOC = 2'b01,
    XT_SET   = 2'b10,
    XT_STAT  = 2'b11
  } xfer_t;

  typedef enum logic [1:0] {
    AD_MATCH,
    AD_CLEAR,
    AD_FOREIGN
  } adec_t;

  localparam logic [5:0] DEV_TAG    = 6'b001000;
  localparam int         STAT_BYTES = 2;
  localparam int         PEAK_BYTES = 4;
  localparam int         RD_BYTES   = STAT_BYTES + PEAK_BYTES;
  localparam int         EXT_BYTES  = 1;
  localparam int         SET_BYTES  = 2;

  // Classify a completed 8-bit address.
  function automatic adec_t addr_class(input logic [7:0] a);
    if (a == 8'h00)              return AD_CLEAR;
    else if (a[7:2] == DEV_TAG)  return AD_MATCH;
    else                         return AD_FOREIGN;
  endfunction

  // Whether a write byte at position idx is passed on for this type.
  function automatic logic wr_accept(input xfer_t t, input int unsigned idx);
    case (t)
      XT_EXT:   return idx < EXT_BYTES;
      XT_SET:   return idx < SET_BYTES;
      XT_ALLOC: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  // Whether a read position maps to a status or peak byte.
  function automatic logic rd_in_range(input int unsigned idx);
    return idx < RD_BYTES;
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_front.sv
module tw_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic sclk_i,
  input  logic dat_i,
  output logic mode_s,
  output logic mode_prev,
  output logic dat_s,
  output logic clk_rise,
  output logic mode_rise,
  output logic mode_fall
);
  logic [2:0] raw, synced;
  logic       clk_prev;

  assign raw = {mode_i, sclk_i, dat_i};

  tw_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_prev  <= 1'b1;
      mode_prev <= 1'b1;
    end else begin
      clk_prev  <= synced[1];
      mode_prev <= synced[2];
    end

  assign mode_s    = synced[2];
  assign dat_s     = synced[0];
  assign clk_rise  = synced[1] & ~clk_prev;
  assign mode_rise = mode_s & ~mode_prev;
  assign mode_fall = ~mode_s & mode_prev;
endmodule

// File: rtl/tw_core.sv
module tw_core
  import tw_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_s,
  input  logic             mode_prev,
  input  logic             dat_s,
  input  logic             clk_rise,
  input  logic             mode_rise,
  input  logic             mode_fall,
  output logic             sel,
  output xfer_t            xtype,
  output logic             wr_stb,
  output logic [7:0]       wr_byte,
  output logic [IDX_W-1:0] wr_idx,
  output logic             load,
  output logic [IDX_W-1:0] load_idx,
  output logic             rd_shift,
  output logic             oe,
  output logic             addr_done,
  output logic             byte_done
);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [3:0]       CNT_MAX = '1;

  logic [7:0]       sh_q, sh_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             sel_q, sel_n;
  xfer_t            type_q, type_n;
  logic             wr_fire, load_n;

  always_comb begin
    sh_n      = sh_q;
    cnt_n     = cnt_q;
    idx_n     = idx_q;
    sel_n     = sel_q;
    type_n    = type_q;
    wr_fire   = 1'b0;
    rd_shift  = 1'b0;
    byte_done = 1'b0;
    addr_done = 1'b0;
    load_n    = 1'b0;

    // Bit taken in the phase that held before any mode change this cycle.
    if (clk_rise) begin
      if (!mode_prev) begin
        sh_n = {dat_s, sh_q[7:1]};
        if (cnt_q != CNT_MAX) cnt_n = cnt_q + 4'd1;
      end else if (sel_q) begin
        if (type_q == XT_STAT) rd_shift = 1'b1;
        else                   sh_n = {dat_s, sh_q[7:1]};
        cnt_n = cnt_q + 4'd1;
        if (cnt_q == 4'd7) begin
          byte_done = 1'b1;
          cnt_n     = '0;
          if (type_q == XT_STAT) load_n  = 1'b1;
          else                   wr_fire = wr_accept(type_q, 32'(idx_q));
          if (idx_q != IDX_MAX) idx_n = idx_q + IDX_ONE;
        end
      end
    end

    // Entering a LOW phase drops any partial data byte.
    if (mode_fall) cnt_n = '0;

    if (mode_rise) begin
      if (cnt_n == 4'd8) begin
        addr_done = 1'b1;
        idx_n     = '0;
        if (addr_class(sh_n) == AD_MATCH) begin
          sel_n  = 1'b1;
          type_n = xfer_t'(sh_n[1:0]);
        end else begin
          sel_n  = 1'b0;
        end
      end else if (cnt_n != 4'd0) begin
        sel_n = 1'b0;
        idx_n = '0;
      end
      cnt_n = '0;
      if (sel_n && type_n == XT_STAT) load_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      sel_q    <= 1'b0;
      type_q   <= XT_EXT;
      wr_stb   <= 1'b0;
      wr_byte  <= '0;
      wr_idx   <= '0;
      load     <= 1'b0;
      load_idx <= '0;
      oe       <= 1'b0;
    end else begin
      sh_q     <= sh_n;
      cnt_q    <= cnt_n;
      idx_q    <= idx_n;
      sel_q    <= sel_n;
      type_q   <= type_n;
      wr_stb   <= wr_fire;
      if (wr_fire) begin
        wr_byte <= sh_n;
        wr_idx  <= idx_q;
      end
      load     <= load_n;
      load_idx <= idx_n;
      oe       <= sel_n && (type_n == XT_STAT) && mode_s;
    end

  assign sel   = sel_q;
  assign xtype = type_q;
endmodule

// File: rtl/tw_rd_shift.sv
module tw_rd_shift
  import tw_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             shift,
  input  logic [7:0]       rd_byte,
  output logic             rd_req,
  output logic             dat_o
);
  logic [7:0] sr;

  assign rd_req = load && rd_in_range(32'(load_idx));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= rd_req ? rd_byte : 8'h00;
    else if (shift) sr <= {1'b0, sr[7:1]};

  assign dat_o = sr[0];
endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
  import tw_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_mode_i,
  input  logic             bus_clk_i,
  input  logic             bus_dat_i,
  output logic             bus_dat_o,
  output logic             bus_dat_oe_o,
  output logic             sel_o,
  output logic [1:0]       xfer_type_o,
  output logic             wr_stb_o,
  output logic [7:0]       wr_byte_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             rd_req_o,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [7:0]       rd_byte_i
);
  logic       mode_s, mode_prev, dat_s, clk_rise, mode_rise, mode_fall;
  logic       load, rd_shift, addr_done, byte_done;
  xfer_t      xtype;

  tw_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .mode_i(bus_mode_i), .sclk_i(bus_clk_i), .dat_i(bus_dat_i),
    .mode_s(mode_s), .mode_prev(mode_prev), .dat_s(dat_s),
    .clk_rise(clk_rise), .mode_rise(mode_rise), .mode_fall(mode_fall)
  );

  tw_core #(.IDX_W(IDX_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .mode_s(mode_s), .mode_prev(mode_prev), .dat_s(dat_s),
    .clk_rise(clk_rise), .mode_rise(mode_rise), .mode_fall(mode_fall),
    .sel(sel_o), .xtype(xtype),
    .wr_stb(wr_stb_o), .wr_byte(wr_byte_o), .wr_idx(wr_idx_o),
    .load(load), .load_idx(rd_idx_o), .rd_shift(rd_shift),
    .oe(bus_dat_oe_o), .addr_done(addr_done), .byte_done(byte_done)
  );

  tw_rd_shift #(.IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_idx(rd_idx_o), .shift(rd_shift),
    .rd_byte(rd_byte_i), .rd_req(rd_req_o), .dat_o(bus_dat_o)
  );

  assign xfer_type_o = xtype;
endmodule

// File: rtl/tw_ctrl_slave_chk.sv
module tw_ctrl_slave_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_o,
  input logic [1:0]       xfer_type_o,
  input logic             bus_dat_oe_o,
  input logic             wr_stb_o,
  input logic             rd_req_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             addr_done,
  input logic             byte_done
);
  a_r6_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dat_oe_o |-> (sel_o && xfer_type_o == 2'b11));

  a_r5_strobe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (sel_o && xfer_type_o != 2'b11));

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  a_r5_strobe_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(byte_done));

  a_r7_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_idx_o < IDX_W'(6) && sel_o && xfer_type_o == 2'b11));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb_o, rd_req_o}));

  a_r3_addr_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> !wr_stb_o);
endmodule

bind tw_ctrl_slave tw_ctrl_slave_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_o(sel_o), .xfer_type_o(xfer_type_o),
  .bus_dat_oe_o(bus_dat_oe_o), .wr_stb_o(wr_stb_o), .rd_req_o(rd_req_o),
  .rd_idx_o(rd_idx_o), .addr_done(addr_done), .byte_done(byte_done)
);

// File: tb/tw_ctrl_slave_tb_top.sv
module tw_ctrl_slave_tb_top;
  localparam int IDX_W = 6;
  localparam int HB    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b1, sclk = 1'b1, dat = 1'b0;
  logic bus_dat_o, bus_dat_oe_o, sel_o, wr_stb_o, rd_req_o;
  logic [1:0] xfer_type_o;
  logic [7:0] wr_byte_o, rd_byte_i;
  logic [IDX_W-1:0] wr_idx_o, rd_idx_o;

  int checks = 0, errors = 0, wr_seen = 0;
  logic [7:0] last_wr_byte = 8'h00;
  logic [IDX_W-1:0] last_wr_idx = '0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  // Local read responder.
  assign rd_byte_i = rd_req_o ? (8'hC3 ^ (8'(rd_idx_o) * 8'h1D)) : 8'h5A;

  tw_ctrl_slave #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode_i(mode), .bus_clk_i(sclk), .bus_dat_i(dat),
    .bus_dat_o(bus_dat_o), .bus_dat_oe_o(bus_dat_oe_o), .sel_o(sel_o),
    .xfer_type_o(xfer_type_o), .wr_stb_o(wr_stb_o), .wr_byte_o(wr_byte_o),
    .wr_idx_o(wr_idx_o), .rd_req_o(rd_req_o), .rd_idx_o(rd_idx_o), .rd_byte_i(rd_byte_i)
  );

  always @(posedge clk)
    if (wr_stb_o) begin
      wr_seen      = wr_seen + 1;
      last_wr_byte = wr_byte_o;
      last_wr_idx  = wr_idx_o;
    end

  function automatic logic [7:0] exp_rd(input int k);
    if (k < 6) return 8'hC3 ^ 8'(k * 29);
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hb();
    repeat (HB) @(negedge clk);
  endtask

  task automatic bus_addr(input logic [7:0] a, input bit coincide);
    mode = 1'b0; hb();
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; dat = a[i]; hb();
      sclk = 1'b1;
      if (i == 7 && coincide) mode = 1'b1;
      hb();
    end
    mode = 1'b1; hb(); hb();
  endtask

  task automatic bus_write(input logic [7:0] b, input bit end_low);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; dat = b[i]; hb();
      sclk = 1'b1;
      if (i == 7 && end_low) mode = 1'b0;
      hb();
    end
    hb();
  endtask

  task automatic bus_read(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; hb();
      b[i] = bus_dat_o;
      sclk = 1'b1; hb();
    end
    hb();
  endtask

  task automatic bus_halt();
    mode = 1'b0; hb();
    mode = 1'b1; hb(); hb();
  endtask

  // {address, byte0, byte1, byte2, expected strobes}
  localparam logic [39:0] WR_VEC [7] = '{
    {8'h22, 8'h11, 8'h22, 8'h33, 8'd2},
    {8'h20, 8'h44, 8'h55, 8'h66, 8'd1},
    {8'h21, 8'h77, 8'h88, 8'h99, 8'd3},
    {8'h2A, 8'h12, 8'h34, 8'h56, 8'd0},
    {8'h00, 8'hAB, 8'hCD, 8'hEF, 8'd0},
    {8'hA2, 8'h01, 8'h02, 8'h03, 8'd0},
    {8'h23, 8'hF0, 8'h0F, 8'hFF, 8'd0}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hb();
    chk("R1 sel", sel_o, 0);
    chk("R1 oe", bus_dat_oe_o, 0);
    chk("R1 wr_stb", wr_stb_o, 0);
    chk("R1 rd_req", rd_req_o, 0);

    // Table of write transfers (R3, R4, R5).
    for (int v = 0; v < 7; v++) begin
      logic [39:0] e;
      int base, n;
      e = WR_VEC[v];
      base = wr_seen;
      n = int'(e[7:0]);
      bus_addr(e[39:32], 1'b0);
      chk("R3 sel", sel_o, (e[39:34] == 6'b001000) ? 1 : 0);
      bus_write(e[31:24], 1'b0);
      bus_write(e[23:16], 1'b0);
      bus_write(e[15:8], 1'b0);
      chk("R5 strobe count", wr_seen - base, n);
      if (n > 0) begin
        chk("R3 type", xfer_type_o, e[33:32]);
        chk("R5 last byte", last_wr_byte, (n == 1) ? e[31:24] : (n == 2) ? e[23:16] : e[15:8]);
        chk("R5 last index", last_wr_idx, n - 1);
      end
    end

    // R2: LSB first, 0x44 must not select.
    bus_addr(8'h44, 1'b0);
    chk("R2 lsb first", sel_o, 0);

    // Status and peak read with a halt between (R6, R7, R8).
    bus_addr(8'h23, 1'b0);
    chk("R3 read type", xfer_type_o, 2'b11);
    chk("R6 oe in data", bus_dat_oe_o, 1);
    for (int k = 0; k < 2; k++) begin
      bus_read(rb);
      chk("R7 status byte", rb, exp_rd(k));
    end
    bus_halt();
    chk("R8 sel kept", sel_o, 1);
    for (int k = 2; k < 7; k++) begin
      bus_read(rb);
      chk("R7 peak/overrun byte", rb, exp_rd(k));
    end
    mode = 1'b0; hb(); hb();
    chk("R6 oe low in halt", bus_dat_oe_o, 0);
    mode = 1'b1; hb(); hb();

    // New address restarts the index (R7).
    bus_addr(8'h23, 1'b0);
    bus_read(rb);
    chk("R7 restart", rb, exp_rd(0));
    // Partial byte discarded by halt (R8).
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; hb(); sclk = 1'b1; hb();
    end
    bus_halt();
    bus_read(rb);
    chk("R8 partial discarded", rb, exp_rd(1));

    // Foreign address during read keeps pad released (R4).
    bus_addr(8'h47, 1'b0);
    chk("R4 foreign oe", bus_dat_oe_o, 0);
    chk("R4 foreign sel", sel_o, 0);

    // All-zero address clears selection (R4).
    bus_addr(8'h22, 1'b0);
    bus_addr(8'h00, 1'b0);
    begin
      int base;
      base = wr_seen;
      bus_write(8'h5C, 1'b0);
      chk("R4 zero address no strobe", wr_seen - base, 0);
      chk("R4 zero address sel", sel_o, 0);
    end

    // Short address phase deselects (R4).
    bus_addr(8'h22, 1'b0);
    mode = 1'b0; hb();
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; dat = 1'b1; hb(); sclk = 1'b1; hb();
    end
    mode = 1'b1; hb(); hb();
    begin
      int base;
      base = wr_seen;
      bus_write(8'h3D, 1'b0);
      chk("R4 short address no strobe", wr_seen - base, 0);
    end

    // Coincident edges (R9), then halt keeps index (R8).
    bus_addr(8'h22, 1'b1);
    chk("R9 address at mode rise sel", sel_o, 1);
    chk("R9 address at mode rise type", xfer_type_o, 2'b10);
    begin
      int base;
      base = wr_seen;
      bus_write(8'hB6, 1'b1);
      chk("R9 byte at mode fall", wr_seen - base, 1);
      chk("R9 byte value", last_wr_byte, 8'hB6);
      mode = 1'b1; hb(); hb();
      bus_write(8'h6B, 1'b0);
      chk("R8 index after halt", last_wr_idx, 1);
      chk("R8 byte after halt", last_wr_byte, 8'h6B);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule